// File: doc/BRIEF.md
# DRAM Multi-Phase Command Steerer

This block sits between the command sources of a DRAM controller and the per-phase command lanes of a multi-phase DRAM PHY interface. Each clock, every phase has its own 2-bit select. The select picks one of four sources for that phase:

- an idle (NOP) source;
- the command chooser;
- the request chooser;
- the refresher.

The phases are steered independently, so one phase can carry a refresh while another carries a write in the same cycle.

The chosen source gives positive-sense strobes (cas, ras, we), a row/column address and a combined rank+bank field. The block gates the strobes with that source's valid and ready, then inverts them to active-low. It splits the combined bank field into a bank address and a one-hot active-low chip select. A refresh asserts every chip select. All phase outputs are registered. The reset, clock-enable and termination lines of each phase are tied active.

The block has no state machine. The per-phase "state" is the decoded source selection, an enumerated type with four named values: `SRC_IDLE`, `SRC_CMD`, `SRC_REQ` and `SRC_REF`. There are no transitions between them: a new selection is taken every cycle.

Top module: `dram_phase_steer`

## Requirements
- R1: Each phase p takes its select from `phase_sel[2p+1:2p]`, with encoding 0 = idle, 1 = command source (slot 0), 2 = request source (slot 1), 3 = refresh source (slot 2). Phases are steered independently of each other.
- R2: A phase whose select is 0 drives `cas_n`, `ras_n` and `we_n` all high.
- R3: A selected source whose valid and ready are not both high leaves that phase's three strobes high. Its bank and address still pass through to the phase outputs.
- R4: A selected source with valid and ready both high drives each active-low strobe as the inverse of its positive strobe. An activate (ras only) gives cas_n=1, ras_n=0, we_n=1. A refresh (cas and ras) gives cas_n=0, ras_n=0, we_n=1.
- R5: With one rank, the whole bank field is the phase bank output, and `cs_n` is 0.
- R6: With more than one rank, the upper clog2(ranks) bits of the bank field select the rank and the remaining lower bits are the bank. `cs_n` is the inverted one-hot of the rank. With 2 ranks and a 3-bit field: 0b110 gives bank 0b10 and cs_n 0b01; 0b101 gives bank 0b01 and cs_n 0b01; 0b001 gives bank 0b01 and cs_n 0b10.
- R7: When the refresh source is selected, every chip select of that phase is asserted (`cs_n` all zeros), whatever its bank field holds.
- R8: `ph_reset_n` is 1 on every phase, and `ph_cke` and `ph_odt` are all ones across every rank of every phase, at all times, including during reset.
- R9: Phase outputs are registered: a change of select or source inputs shows on the outputs after exactly one rising clock edge.
- R10: While reset is low, every strobe is high, every `cs_n` bit is high, and bank and address are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_sel | input | 2*NPHASE | Per-phase source select, 2 bits per phase |
| src_valid | input | 3 | Valid of command, request and refresh sources (slots 0, 1, 2) |
| src_ready | input | 3 | Ready of each source slot |
| src_cas | input | 3 | Positive cas strobe of each source |
| src_ras | input | 3 | Positive ras strobe of each source |
| src_we | input | 3 | Positive we strobe of each source |
| src_addr | input | 3*ABITS | Address of each source, slot s at bits [s*ABITS +: ABITS] |
| src_ba | input | 3*BABITS | Combined rank+bank field of each source |
| ph_cas_n | output | NPHASE | Active-low cas per phase |
| ph_ras_n | output | NPHASE | Active-low ras per phase |
| ph_we_n | output | NPHASE | Active-low we per phase |
| ph_bank | output | NPHASE*BKW | Bank address per phase |
| ph_addr | output | NPHASE*ABITS | Address per phase |
| ph_cs_n | output | NPHASE*NRANK | Active-low chip selects per phase |
| ph_reset_n | output | NPHASE | Device reset per phase, tied high |
| ph_cke | output | NPHASE*NRANK | Clock enable per rank per phase, tied high |
| ph_odt | output | NPHASE*NRANK | Termination enable per rank per phase, tied high |

## Verification
The bench holds a source valid while ready is low. A design that gated the strobes on valid alone would show an activate too early. The same check confirms that bank and address still pass through.

It walks the rank decode with field values whose upper and lower bits differ, which catches a swapped rank/bank split or a non-inverted chip select. It then repeats those values under refresh, where a design that forgot to force all ranks would still select a single rank.

It drives a write on one phase and a refresh on the other in the same cycle, to expose phases that share selection logic. It also samples just before the clock edge to expose a missing or doubled output register. A second instance with one rank checks that the whole field passes as bank and that the chip select stays asserted.

// File: rtl/steer_pkg.sv
package steer_pkg;
    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_CMD  = 2'd1,
        SRC_REQ  = 2'd2,
        SRC_REF  = 2'd3
    } src_sel_e;

    localparam int NSRC = 3;
endpackage

// File: rtl/steer_rank_decode.sv
module steer_rank_decode #(
    parameter int BABITS = 3,
    parameter int NRANK  = 2,
    parameter int BKW    = 2
) (
    input  logic [BABITS-1:0] ba,
    input  logic              all_ranks,
    output logic [BKW-1:0]    bank,
    output logic [NRANK-1:0]  cs_n
);
    generate
        if (NRANK == 1) begin : g_single
            // the whole field is bank; the only rank is always selected
            assign bank = ba;
            assign cs_n = '0;
        end else begin : g_multi
            localparam int RBW = $clog2(NRANK);
            logic [RBW-1:0] rank;
            assign rank = ba[BABITS-1 -: RBW];
            assign bank = ba[BKW-1:0];
            for (genvar r = 0; r < NRANK; r++) begin : g_cs
                assign cs_n[r] = ~(all_ranks | (rank == RBW'(r)));
            end
        end
    endgenerate
endmodule

// File: rtl/steer_phase.sv
module steer_phase
    import steer_pkg::*;
#(
    parameter int ABITS  = 13,
    parameter int BABITS = 3,
    parameter int NRANK  = 2,
    parameter int BKW    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             sel,
    input  logic [NSRC-1:0]        src_valid,
    input  logic [NSRC-1:0]        src_ready,
    input  logic [NSRC-1:0]        src_cas,
    input  logic [NSRC-1:0]        src_ras,
    input  logic [NSRC-1:0]        src_we,
    input  logic [NSRC*ABITS-1:0]  src_addr,
    input  logic [NSRC*BABITS-1:0] src_ba,
    output logic                   cas_n,
    output logic                   ras_n,
    output logic                   we_n,
    output logic [BKW-1:0]         bank,
    output logic [ABITS-1:0]       addr,
    output logic [NRANK-1:0]       cs_n
);
    src_sel_e          sel_e;
    logic              use_src;
    logic              is_ref;
    logic [1:0]        slot;
    logic              fire;
    logic              pick_cas, pick_ras, pick_we;
    logic [ABITS-1:0]  pick_addr;
    logic [BABITS-1:0] pick_ba;
    logic [BKW-1:0]    nxt_bank;
    logic [NRANK-1:0]  nxt_cs_n;

    assign sel_e = src_sel_e'(sel);

    // source selection
    always_comb begin
        use_src = 1'b1;
        is_ref  = 1'b0;
        slot    = 2'd0;
        unique case (sel_e)
            SRC_IDLE: use_src = 1'b0;
            SRC_CMD:  slot = 2'd0;
            SRC_REQ:  slot = 2'd1;
            SRC_REF: begin
                slot   = 2'd2;
                is_ref = 1'b1;
            end
        endcase
    end

    // field pick and strobe gating
    always_comb begin
        fire      = 1'b0;
        pick_cas  = 1'b0;
        pick_ras  = 1'b0;
        pick_we   = 1'b0;
        pick_addr = '0;
        pick_ba   = '0;
        if (use_src) begin
            fire      = src_valid[slot] & src_ready[slot];
            pick_cas  = src_cas[slot];
            pick_ras  = src_ras[slot];
            pick_we   = src_we[slot];
            pick_addr = src_addr[int'(slot)*ABITS +: ABITS];
            pick_ba   = src_ba[int'(slot)*BABITS +: BABITS];
        end
    end

    steer_rank_decode #(
        .BABITS(BABITS),
        .NRANK (NRANK),
        .BKW   (BKW)
    ) rank_dec_i (
        .ba       (pick_ba),
        .all_ranks(is_ref),
        .bank     (nxt_bank),
        .cs_n     (nxt_cs_n)
    );

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cas_n <= 1'b1;
            ras_n <= 1'b1;
            we_n  <= 1'b1;
            bank  <= '0;
            addr  <= '0;
            cs_n  <= '1;
        end else begin
            cas_n <= ~(fire & pick_cas);
            ras_n <= ~(fire & pick_ras);
            we_n  <= ~(fire & pick_we);
            bank  <= nxt_bank;
            addr  <= pick_addr;
            cs_n  <= nxt_cs_n;
        end
    end

    // R2: idle phase carries no command
    a_r2_idle_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_IDLE) |=> (cas_n && ras_n && we_n));

    // R3: command source without handshake stays silent
    a_r3_cmd_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_CMD && !(src_valid[0] && src_ready[0])) |=> (cas_n && ras_n && we_n));

    // R4: refresh strobes are the inverse of the positive request
    a_r4_ref_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_REF && src_valid[2] && src_ready[2]) |=>
            (cas_n == !$past(src_cas[2]) && ras_n == !$past(src_ras[2]) && we_n == !$past(src_we[2])));

    // R7: refresh asserts every chip select
    a_r7_ref_all_ranks: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_REF) |=> (cs_n == '0));

    // R6: outside refresh at most one rank is selected
    a_r6_single_rank: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != SRC_REF) |=> ($countones(~cs_n) <= 1));
endmodule

// File: rtl/dram_phase_steer.sv
module dram_phase_steer
    import steer_pkg::*;
#(
    parameter int NPHASE = 2,
    parameter int NRANK  = 2,
    parameter int ABITS  = 13,
    parameter int BABITS = 3,
    localparam int BKW   = (NRANK > 1) ? BABITS - $clog2(NRANK) : BABITS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2*NPHASE-1:0]       phase_sel,
    input  logic [2:0]                src_valid,
    input  logic [2:0]                src_ready,
    input  logic [2:0]                src_cas,
    input  logic [2:0]                src_ras,
    input  logic [2:0]                src_we,
    input  logic [3*ABITS-1:0]        src_addr,
    input  logic [3*BABITS-1:0]       src_ba,
    output logic [NPHASE-1:0]         ph_cas_n,
    output logic [NPHASE-1:0]         ph_ras_n,
    output logic [NPHASE-1:0]         ph_we_n,
    output logic [NPHASE*BKW-1:0]     ph_bank,
    output logic [NPHASE*ABITS-1:0]   ph_addr,
    output logic [NPHASE*NRANK-1:0]   ph_cs_n,
    output logic [NPHASE-1:0]         ph_reset_n,
    output logic [NPHASE*NRANK-1:0]   ph_cke,
    output logic [NPHASE*NRANK-1:0]   ph_odt
);
    // static device controls (R8)
    assign ph_reset_n = '1;
    assign ph_cke     = '1;
    assign ph_odt     = '1;

    generate
        for (genvar p = 0; p < NPHASE; p++) begin : g_phase
            steer_phase #(
                .ABITS (ABITS),
                .BABITS(BABITS),
                .NRANK (NRANK),
                .BKW   (BKW)
            ) phase_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .sel      (phase_sel[2*p +: 2]),
                .src_valid(src_valid),
                .src_ready(src_ready),
                .src_cas  (src_cas),
                .src_ras  (src_ras),
                .src_we   (src_we),
                .src_addr (src_addr),
                .src_ba   (src_ba),
                .cas_n    (ph_cas_n[p]),
                .ras_n    (ph_ras_n[p]),
                .we_n     (ph_we_n[p]),
                .bank     (ph_bank[p*BKW +: BKW]),
                .addr     (ph_addr[p*ABITS +: ABITS]),
                .cs_n     (ph_cs_n[p*NRANK +: NRANK])
            );
        end
    endgenerate
endmodule

// File: tb/dram_phase_steer_tb_top.sv
module dram_phase_steer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  sel_a = '0;
    logic [7:0]  sel_b = '0;
    logic [2:0]  valid = '0, ready = '0, cas = '0, ras = '0, we = '0;
    logic [38:0] addr = '0;
    logic [8:0]  ba = '0;

    logic [1:0]  a_cas_n, a_ras_n, a_we_n, a_reset_n;
    logic [3:0]  a_bank, a_cs_n, a_cke, a_odt;
    logic [25:0] a_addr;
    logic [3:0]  b_cas_n, b_ras_n, b_we_n, b_reset_n, b_cs_n, b_cke, b_odt;
    logic [11:0] b_bank;
    logic [51:0] b_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dram_phase_steer dut_i (
        .clk(clk), .rst_n(rst_n), .phase_sel(sel_a),
        .src_valid(valid), .src_ready(ready), .src_cas(cas), .src_ras(ras), .src_we(we),
        .src_addr(addr), .src_ba(ba),
        .ph_cas_n(a_cas_n), .ph_ras_n(a_ras_n), .ph_we_n(a_we_n), .ph_bank(a_bank),
        .ph_addr(a_addr), .ph_cs_n(a_cs_n), .ph_reset_n(a_reset_n), .ph_cke(a_cke), .ph_odt(a_odt)
    );

    dram_phase_steer #(.NPHASE(4), .NRANK(1)) dut1_i (
        .clk(clk), .rst_n(rst_n), .phase_sel(sel_b),
        .src_valid(valid), .src_ready(ready), .src_cas(cas), .src_ras(ras), .src_we(we),
        .src_addr(addr), .src_ba(ba),
        .ph_cas_n(b_cas_n), .ph_ras_n(b_ras_n), .ph_we_n(b_we_n), .ph_bank(b_bank),
        .ph_addr(b_addr), .ph_cs_n(b_cs_n), .ph_reset_n(b_reset_n), .ph_cke(b_cke), .ph_odt(b_odt)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // slot 0 command, 1 request, 2 refresh
    task automatic set_src(input int s, input logic v, input logic r, input logic c, input logic ra,
                           input logic w, input logic [12:0] a, input logic [2:0] b);
        valid[s] = v; ready[s] = r; cas[s] = c; ras[s] = ra; we[s] = w;
        addr[s*13 +: 13] = a;
        ba[s*3 +: 3] = b;
    endtask

    // phase p strobes as {cas_n, ras_n, we_n}
    function automatic logic [2:0] strb_a(input int p);
        return {a_cas_n[p], a_ras_n[p], a_we_n[p]};
    endfunction

    task automatic t_reset();
        repeat (2) @(negedge clk);
        chk("R10", "strobes in reset", {a_cas_n, a_ras_n, a_we_n}, 6'b111111);
        chk("R10", "cs_n in reset", a_cs_n, 4'b1111);
        chk("R10", "addr in reset", a_addr, 0);
        chk("R8", "reset_n in reset", a_reset_n, 2'b11);
        chk("R8", "cke/odt in reset", {a_cke, a_odt}, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_idle();
        set_src(0, 1, 1, 0, 1, 0, 13'h11, 3'b001);
        set_src(2, 1, 1, 1, 1, 0, 13'h12, 3'b010);
        sel_a = 4'b0000;
        @(negedge clk);
        chk("R2", "idle phase0 strobes", strb_a(0), 3'b111);
        chk("R2", "idle phase1 strobes", strb_a(1), 3'b111);
        chk("R8", "cke/odt active", {a_cke, a_odt, a_reset_n}, 10'h3FF);
    endtask

    task automatic t_gate();
        set_src(0, 1, 0, 0, 1, 0, 13'h5, 3'b110);
        sel_a = 4'b0001;
        @(negedge clk);
        chk("R3", "not ready strobes", strb_a(0), 3'b111);
        chk("R3", "not ready bank", a_bank[1:0], 2'b10);
        chk("R3", "not ready addr", a_addr[12:0], 13'h5);
        ready[0] = 1'b1;
        #1;
        chk("R9", "before edge unchanged", strb_a(0), 3'b111);
        @(negedge clk);
        chk("R4", "activate strobes", strb_a(0), 3'b101);
        chk("R2", "idle phase1 beside active", strb_a(1), 3'b111);
        valid[0] = 1'b0;
        @(negedge clk);
        chk("R3", "not valid strobes", strb_a(0), 3'b111);
        valid[0] = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_rank();
        set_src(0, 1, 1, 0, 1, 0, 13'h7, 3'b110);
        @(negedge clk);
        chk("R6", "ba110 bank", a_bank[1:0], 2'b10);
        chk("R6", "ba110 cs_n", a_cs_n[1:0], 2'b01);
        set_src(0, 1, 1, 0, 1, 0, 13'h7, 3'b101);
        @(negedge clk);
        chk("R6", "ba101 bank", a_bank[1:0], 2'b01);
        chk("R6", "ba101 cs_n", a_cs_n[1:0], 2'b01);
        set_src(0, 1, 1, 0, 1, 0, 13'h7, 3'b001);
        @(negedge clk);
        chk("R6", "ba001 bank", a_bank[1:0], 2'b01);
        chk("R6", "ba001 cs_n", a_cs_n[1:0], 2'b10);
    endtask

    task automatic t_refresh();
        logic [2:0] bav [3] = '{3'b110, 3'b101, 3'b001};
        logic [1:0] bkv [3] = '{2'b10, 2'b01, 2'b01};
        sel_a = 4'b0011;
        for (int i = 0; i < 3; i++) begin
            set_src(2, 1, 1, 1, 1, 0, 13'h0, bav[i]);
            @(negedge clk);
            chk("R7", "refresh cs_n", a_cs_n[1:0], 2'b00);
            chk("R7", "refresh bank", a_bank[1:0], bkv[i]);
            chk("R4", "refresh strobes", strb_a(0), 3'b001);
        end
    endtask

    task automatic t_indep();
        set_src(1, 1, 1, 1, 0, 1, 13'h44, 3'b010);
        set_src(2, 1, 1, 1, 1, 0, 13'h0, 3'b101);
        sel_a = 4'b1110; // phase0 request, phase1 refresh
        @(negedge clk);
        chk("R1", "phase0 write strobes", strb_a(0), 3'b010);
        chk("R1", "phase0 cs_n", a_cs_n[1:0], 2'b10);
        chk("R1", "phase0 bank", a_bank[1:0], 2'b10);
        chk("R1", "phase0 addr", a_addr[12:0], 13'h44);
        chk("R1", "phase1 refresh strobes", strb_a(1), 3'b001);
        chk("R1", "phase1 cs_n", a_cs_n[3:2], 2'b00);
        chk("R1", "phase1 bank", a_bank[3:2], 2'b01);
    endtask

    task automatic t_single();
        set_src(0, 1, 1, 0, 1, 0, 13'h3, 3'b110);
        sel_b = 8'b00_01_00_00; // phase2 command source
        @(negedge clk);
        chk("R5", "one rank bank", b_bank[8:6], 3'b110);
        chk("R5", "one rank cs_n", b_cs_n, 4'b0000);
        chk("R5", "one rank activate", {b_cas_n[2], b_ras_n[2], b_we_n[2]}, 3'b101);
        chk("R2", "one rank idle phases", {b_ras_n[3], b_ras_n[1], b_ras_n[0]}, 3'b111);
        chk("R8", "one rank static lines", {b_reset_n, b_cke, b_odt}, 12'hFFF);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle();
        t_gate();
        t_rank();
        t_refresh();
        t_indep();
        t_single();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired (R1..R10 incomplete)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule